// File: doc/BRIEF.md
# Dual-Identity I2C Target Front End

This block is the serial front end of an I2C target that answers to two fixed 7-bit device identifiers. After a Start condition it shifts in a control byte, most significant bit first. If the upper seven bits match one of the two identifiers, it acknowledges the byte and records the direction bit, which is the least significant bit. One identifier selects a nonvolatile memory space. The other selects a register space, where registers and SRAM share one address range. The memory arrays sit outside the block on a simple byte bus.

A write transfer sends an address byte and then any number of data bytes. Each data byte produces one write strobe, and the internal address then advances by one. A read transfer is started with a repeated Start and a read control byte. It returns bytes from the current address, and the address advances after each byte is fetched. A not-acknowledge from the master ends the read.

In the memory space, address bit 7 is dropped for normal accesses. When the dedicated ID-path input is high, the same bit steers the access into a unique-ID and status region instead. SDA and SCL pass through a synchronizer that runs on the system clock. That clock must be at least eight times the SCL rate.

Top module: `dual_id_i2c_target`

## Requirements
- R1: After reset, `sdaOe`, `busWe` and `busRe` are all 0.
- R2: A control byte whose upper seven bits equal 1010111 is acknowledged: `sdaOe` is 1 during the ninth clock. Accesses that follow use `busSpace` = 0, the memory space.
- R3: A control byte whose upper seven bits equal 1101111 is acknowledged. Accesses that follow use `busSpace` = 1, the register space.
- R4: Any other control byte is not acknowledged. After it, the block drives no SDA and raises no strobe until the next Start condition, and a fresh Start with a matching code is acknowledged again.
- R5: In a write (direction bit 0), the byte after the control byte loads the address. Each further byte raises `busWe` for exactly one cycle, with `busWdata` equal to that byte and `busAddr` equal to the current address. The address then increments and wraps modulo 256.
- R6: A read control byte (direction bit 1) causes a fetch of `busRdata` at the current address, with a one-cycle `busRe` pulse. The byte is sent MSB first, and the address increments. A repeated Start followed by a read control byte therefore returns data from the address set by the preceding write of an address byte. A new Start and read without an address byte continues from the address after the last fetched byte.
- R7: After each read byte, SDA is released for the acknowledge slot. A master ACK (SDA low) fetches and sends the next byte. A master NACK ends the read: there is no further fetch, and `sdaOe` stays 0 until a Stop or Start.
- R8: In the memory space with `idPathEn` = 0, address bit 7 is ignored. `busAddr[7]` is 0, so the address wraps from 127 to 0, and `busIdSel` is 0.
- R9: In the memory space with `idPathEn` = 1 and address bit 7 set, `busIdSel` is 1 and `busAddr` carries the full byte.
- R10: After a Stop, SCL pulses without a Start are ignored: there is no acknowledge and no strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x SCL |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | SCL line as seen at the pin |
| sdaIn | input | 1 | SDA line as seen at the pin |
| sdaOe | output | 1 | 1 pulls SDA low (open drain) |
| idPathEn | input | 1 | Enables the unique-ID/status region through address bit 7 |
| busSpace | output | 1 | 0 memory space, 1 register space |
| busIdSel | output | 1 | Access targets the ID/status region |
| busAddr | output | 8 | Byte address |
| busWdata | output | 8 | Write data |
| busWe | output | 1 | One-cycle write strobe |
| busRe | output | 1 | One-cycle read strobe; busRdata sampled in that cycle |
| busRdata | input | 8 | Read data for busSpace/busAddr |

## Verification
The bench builds the block with its default identifiers (1010111 and 1101111) and a two-stage synchronizer. It runs SCL at a quarter period of eight system clocks, which is well above the 8x oversampling floor, so the synchronizer latency of about three cycles always settles inside each SCL phase. With these values, both identifiers, a code that matches neither, and the 127-to-0 and 255-to-0 address wraps are all reachable. The ID path, the NACK release and a current-address read are reachable within a few dozen bytes.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CTRL, ST_ADDR, ST_WRITE, ST_READ, ST_IGNORE
  } tgtState_e;

  // bus events seen after synchronization
  typedef struct packed {
    logic sclRise;
    logic sclFall;
    logic start;
    logic stop;
    logic sdaBit;
  } busEvt_t;

  // control -> datapath strobes and levels
  typedef struct packed {
    logic shiftIn;
    logic shiftOut;
    logic loadTx;
    logic loadAddr;
    logic writeByte;
    logic incAddr;
    logic capSpace;
    logic spaceVal;
    logic ackDrive;
    logic txEn;
  } ctlStrobe_t;
endpackage

// File: rtl/i2ct_datapath.sv
module i2ct_datapath
  import i2ct_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               sclIn,
  input  logic               sdaIn,
  input  ctlStrobe_t         ctl,
  input  logic               idPathEn,
  input  logic [BYTE_W-1:0]  busRdata,
  output busEvt_t            evt,
  output logic [BYTE_W-1:0]  rxByte,
  output logic               sdaOe,
  output logic               busSpace,
  output logic               busIdSel,
  output logic [BYTE_W-1:0]  busAddr,
  output logic [BYTE_W-1:0]  busWdata,
  output logic               busWe,
  output logic               busRe
);
  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] sclSync, sdaSync;
  logic sclPrev, sdaPrev, sclNow, sdaNow;
  logic [BYTE_W-1:0] shiftReg, addrReg;
  logic spaceReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= '1;
      sdaSync <= '1;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[TOP-1:0], sclIn};
      sdaSync <= {sdaSync[TOP-1:0], sdaIn};
      sclPrev <= sclNow;
      sdaPrev <= sdaNow;
    end
  end

  assign sclNow = sclSync[TOP];
  assign sdaNow = sdaSync[TOP];

  assign evt.sclRise = sclNow & ~sclPrev;
  assign evt.sclFall = ~sclNow & sclPrev;
  assign evt.start   = sclNow & sclPrev & sdaPrev & ~sdaNow;
  assign evt.stop    = sclNow & sclPrev & ~sdaPrev & sdaNow;
  assign evt.sdaBit  = sdaNow;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      addrReg  <= '0;
      spaceReg <= 1'b0;
    end else begin
      if (ctl.loadTx)        shiftReg <= busRdata;
      else if (ctl.shiftIn)  shiftReg <= {shiftReg[BYTE_W-2:0], sdaNow};
      else if (ctl.shiftOut) shiftReg <= {shiftReg[BYTE_W-2:0], 1'b1};

      if (ctl.loadAddr)     addrReg <= shiftReg;
      else if (ctl.incAddr) addrReg <= addrReg + 1'b1;

      if (ctl.capSpace) spaceReg <= ctl.spaceVal;
    end
  end

  assign rxByte   = shiftReg;
  assign sdaOe    = ctl.ackDrive | (ctl.txEn & ~shiftReg[BYTE_W-1]);
  assign busSpace = spaceReg;
  assign busIdSel = ~spaceReg & idPathEn & addrReg[BYTE_W-1];
  assign busAddr  = (~spaceReg & ~idPathEn) ? {1'b0, addrReg[BYTE_W-2:0]} : addrReg;
  assign busWdata = shiftReg;
  assign busWe    = ctl.writeByte;
  assign busRe    = ctl.loadTx;

  // R7: no data bit driven while an acknowledge is being driven
  a_r7_no_tx_in_ack: assert property (@(posedge clk) disable iff (!rstN)
    !(ctl.ackDrive && ctl.txEn));
  // R5: write strobe lasts one cycle
  a_r5_we_single: assert property (@(posedge clk) disable iff (!rstN)
    busWe |=> !busWe);
  // R6: read strobe lasts one cycle
  a_r6_re_single: assert property (@(posedge clk) disable iff (!rstN)
    busRe |=> !busRe);
endmodule

// File: rtl/i2ct_control.sv
module i2ct_control
  import i2ct_pkg::*;
#(
  parameter logic [6:0] NV_CODE  = 7'b1010111,
  parameter logic [6:0] REG_CODE = 7'b1101111
) (
  input  logic              clk,
  input  logic              rstN,
  input  busEvt_t           evt,
  input  logic [BYTE_W-1:0] rxByte,
  output ctlStrobe_t        ctl
);
  localparam logic [3:0] LAST_BIT = 4'(BYTE_W);

  tgtState_e state;
  logic [3:0] bitCnt;
  logic ackPhase, ackDrive, rwBit, nackSeen;
  logic active, byteDone, ackEnd, codeMatch, isReg;

  assign isReg     = (rxByte[BYTE_W-1:1] == REG_CODE);
  assign codeMatch = isReg || (rxByte[BYTE_W-1:1] == NV_CODE);
  assign active    = (state == ST_CTRL) || (state == ST_ADDR) ||
                     (state == ST_WRITE) || (state == ST_READ);
  assign byteDone  = active && evt.sclFall && !ackPhase && (bitCnt == LAST_BIT);
  assign ackEnd    = active && evt.sclFall && ackPhase;

  always_comb begin
    ctl           = '0;
    ctl.ackDrive  = ackDrive;
    ctl.txEn      = (state == ST_READ) && !ackPhase;
    ctl.shiftIn   = evt.sclRise && !ackPhase && (bitCnt < LAST_BIT) &&
                    ((state == ST_CTRL) || (state == ST_ADDR) || (state == ST_WRITE));
    ctl.shiftOut  = evt.sclFall && !ackPhase && (state == ST_READ) &&
                    (bitCnt != 4'd0) && (bitCnt < LAST_BIT);
    ctl.capSpace  = byteDone && (state == ST_CTRL) && codeMatch;
    ctl.spaceVal  = isReg;
    ctl.loadAddr  = byteDone && (state == ST_ADDR);
    ctl.writeByte = byteDone && (state == ST_WRITE);
    ctl.loadTx    = ackEnd && (((state == ST_CTRL) && rwBit) ||
                               ((state == ST_READ) && !nackSeen));
    ctl.incAddr   = ctl.writeByte || ctl.loadTx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      ackDrive <= 1'b0;
      rwBit    <= 1'b0;
      nackSeen <= 1'b0;
    end else if (evt.start || evt.stop) begin
      state    <= evt.start ? ST_CTRL : ST_IDLE;
      bitCnt   <= '0;
      ackPhase <= 1'b0;
      ackDrive <= 1'b0;
      nackSeen <= 1'b0;
    end else if (active) begin
      if (evt.sclRise && !ackPhase && (bitCnt < LAST_BIT))
        bitCnt <= bitCnt + 1'b1;
      if (evt.sclRise && ackPhase && (state == ST_READ))
        nackSeen <= evt.sdaBit;
      if (byteDone) begin
        if ((state == ST_CTRL) && !codeMatch) begin
          state <= ST_IGNORE;
        end else begin
          ackPhase <= 1'b1;
          ackDrive <= (state != ST_READ);
          if (state == ST_CTRL) rwBit <= rxByte[0];
        end
      end
      if (ackEnd) begin
        ackPhase <= 1'b0;
        ackDrive <= 1'b0;
        bitCnt   <= '0;
        unique case (state)
          ST_CTRL: state <= rwBit ? ST_READ : ST_ADDR;
          ST_ADDR: state <= ST_WRITE;
          ST_READ: state <= nackSeen ? ST_IGNORE : ST_READ;
          default: state <= state;
        endcase
      end
    end
  end

  // R10: a Stop always returns to idle
  a_r10_stop_to_idle: assert property (@(posedge clk) disable iff (!rstN)
    evt.stop |=> (state == ST_IDLE));
  // R4: nothing is driven while ignoring the bus
  a_r4_ignore_silent: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IGNORE) |-> (!ackDrive && !ctl.txEn));
  // R2: an acknowledge only starts after a full byte
  a_r2_ack_after_byte: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ackDrive) |-> (bitCnt == LAST_BIT && ackPhase));
endmodule

// File: rtl/dual_id_i2c_target.sv
module dual_id_i2c_target
  import i2ct_pkg::*;
#(
  parameter logic [6:0] NV_CODE     = 7'b1010111,
  parameter logic [6:0] REG_CODE    = 7'b1101111,
  parameter int         SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  output logic       sdaOe,
  input  logic       idPathEn,
  output logic       busSpace,
  output logic       busIdSel,
  output logic [7:0] busAddr,
  output logic [7:0] busWdata,
  output logic       busWe,
  output logic       busRe,
  input  logic [7:0] busRdata
);
  busEvt_t    evt;
  ctlStrobe_t ctl;
  logic [BYTE_W-1:0] rxByte;

  i2ct_control #(.NV_CODE(NV_CODE), .REG_CODE(REG_CODE)) u_ctl (
    .clk(clk), .rstN(rstN), .evt(evt), .rxByte(rxByte), .ctl(ctl)
  );

  i2ct_datapath #(.SYNC_STAGES(SYNC_STAGES)) u_dp (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn), .ctl(ctl),
    .idPathEn(idPathEn), .busRdata(busRdata), .evt(evt), .rxByte(rxByte),
    .sdaOe(sdaOe), .busSpace(busSpace), .busIdSel(busIdSel),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe)
  );
endmodule

// File: tb/tb_dual_id_i2c_target.sv
module tb_dual_id_i2c_target;
  localparam int Q = 8;
  localparam logic [6:0] NVC = 7'b1010111;
  localparam logic [6:0] RGC = 7'b1101111;
  // {code, address, data}
  localparam logic [22:0] VEC [4] = '{
    {NVC, 8'h10, 8'h3C}, {RGC, 8'h20, 8'hA5},
    {RGC, 8'hFF, 8'h01}, {NVC, 8'h7F, 8'hF0}};

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, sclM, sdaM, idPathEn, sdaBus;
  logic sdaOe, busSpace, busIdSel, busWe, busRe;
  logic [7:0] busAddr, busWdata, busRdata;
  logic [7:0] tbMem [0:1][0:255];
  logic [7:0] weAddrLog [0:63];
  logic [7:0] weDataLog [0:63];
  logic       weIdLog   [0:63];
  int weCnt, reCnt, oeCnt, checks, failures;

  assign sdaBus   = sdaM & ~sdaOe;
  assign busRdata = tbMem[busSpace][busAddr];

  dual_id_i2c_target dut (
    .clk(clk), .rstN(rstN), .sclIn(sclM), .sdaIn(sdaBus), .sdaOe(sdaOe),
    .idPathEn(idPathEn), .busSpace(busSpace), .busIdSel(busIdSel),
    .busAddr(busAddr), .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .busRdata(busRdata));

  function automatic logic [7:0] patt(input logic sp, input logic [7:0] a);
    return a ^ (sp ? 8'h5A : 8'hC3);
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < 2; s++)
        for (int a = 0; a < 256; a++) tbMem[s][a] <= patt(s[0], a[7:0]);
      weCnt <= 0; reCnt <= 0; oeCnt <= 0;
    end else begin
      if (busWe) begin
        tbMem[busSpace][busAddr] <= busWdata;
        weAddrLog[weCnt[5:0]] <= busAddr;
        weDataLog[weCnt[5:0]] <= busWdata;
        weIdLog[weCnt[5:0]]   <= busIdSel;
        weCnt <= weCnt + 1;
      end
      if (busRe) reCnt <= reCnt + 1;
      if (sdaOe) oeCnt <= oeCnt + 1;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic qw(); repeat (Q) @(negedge clk); endtask

  task automatic i2cStart();
    sdaM = 1; qw(); sclM = 1; qw(); sdaM = 0; qw(); sclM = 0; qw();
  endtask

  task automatic i2cStop();
    sdaM = 0; qw(); sclM = 1; qw(); sdaM = 1; qw(); qw();
  endtask

  task automatic sendByte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sdaM = b[i]; qw(); sclM = 1; qw(); qw(); sclM = 0; qw();
    end
    sdaM = 1; qw(); sclM = 1; qw(); ack = ~sdaBus; qw(); sclM = 0; qw();
  endtask

  task automatic readByte(input logic ackIt, output logic [7:0] v);
    for (int i = 7; i >= 0; i--) begin
      sdaM = 1; qw(); sclM = 1; qw(); v[i] = sdaBus; qw(); sclM = 0; qw();
    end
    sdaM = ~ackIt; qw(); sclM = 1; qw(); qw(); sclM = 0; qw();
  endtask

  task automatic finishRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic ack;
    logic [7:0] v0, v1;
    int base, oe0;
    checks = 0; failures = 0;
    sclM = 1; sdaM = 1; idPathEn = 0; rstN = 0;
    repeat (5) @(negedge clk);
    chk(sdaOe == 0, "R1 sdaOe", sdaOe, 0);
    chk(busWe == 0 && busRe == 0, "R1 strobes", {busWe, busRe}, 0);
    rstN = 1;
    repeat (5) @(negedge clk);

    // table: write two bytes, read them back
    for (int i = 0; i < 4; i++) begin
      logic [6:0] code; logic [7:0] a, d, mask; logic sp;
      code = VEC[i][22:16]; a = VEC[i][15:8]; d = VEC[i][7:0];
      sp = (code == RGC); mask = sp ? 8'hFF : 8'h7F;
      base = weCnt;
      i2cStart(); sendByte({code, 1'b0}, ack);
      chk(ack == 1, sp ? "R3 ack" : "R2 ack", ack, 1);
      sendByte(a, ack); sendByte(d, ack); sendByte(~d, ack);
      i2cStop();
      chk(weCnt - base == 2, "R5 write count", weCnt - base, 2);
      chk(weAddrLog[base[5:0]] == (a & mask), "R5 addr", weAddrLog[base[5:0]], a & mask);
      chk(weDataLog[base[5:0]] == d, "R5 data", weDataLog[base[5:0]], d);
      chk(weAddrLog[6'(base + 1)] == ((a + 8'd1) & mask), "R5 R8 increment",
          weAddrLog[6'(base + 1)], (a + 8'd1) & mask);
      chk(busSpace == sp, sp ? "R3 space" : "R2 space", busSpace, sp);
      base = reCnt;
      i2cStart(); sendByte({code, 1'b0}, ack); sendByte(a, ack);
      i2cStart(); sendByte({code, 1'b1}, ack);
      readByte(1, v0); readByte(0, v1);
      i2cStop();
      chk(v0 == d, "R6 read byte0", v0, d);
      chk(v1 == ~d, "R6 read byte1", v1, ~d);
      chk(reCnt - base == 2, "R7 fetch count", reCnt - base, 2);
    end

    // R6 current-address read: memory space at address 0x01 after wrap
    i2cStart(); sendByte({NVC, 1'b1}, ack); readByte(0, v0); i2cStop();
    chk(v0 == patt(0, 8'h01), "R6 current address", v0, patt(0, 8'h01));

    // R7 after NACK the bus is left released
    i2cStart(); sendByte({RGC, 1'b1}, ack); readByte(0, v0);
    oe0 = oeCnt; readByte(0, v1);
    chk(oeCnt == oe0, "R7 release after nack", oeCnt - oe0, 0);
    chk(v1 == 8'hFF, "R7 idle line", v1, 8'hFF);
    i2cStop();

    // R4 foreign code ignored until next Start
    base = weCnt; oe0 = oeCnt;
    i2cStart(); sendByte({7'b1010000, 1'b0}, ack);
    chk(ack == 0, "R4 no ack", ack, 0);
    sendByte(8'h33, ack); sendByte(8'h44, ack);
    chk(weCnt == base, "R4 no write", weCnt - base, 0);
    chk(oeCnt == oe0, "R4 no drive", oeCnt - oe0, 0);
    i2cStart(); sendByte({RGC, 1'b0}, ack);
    chk(ack == 1, "R4 ack after new start", ack, 1);
    i2cStop();

    // R8 bit 7 ignored without the ID path
    base = weCnt;
    i2cStart(); sendByte({NVC, 1'b0}, ack); sendByte(8'h85, ack); sendByte(8'h66, ack);
    i2cStop();
    chk(weAddrLog[base[5:0]] == 8'h05, "R8 addr masked", weAddrLog[base[5:0]], 8'h05);
    chk(weIdLog[base[5:0]] == 0, "R8 no id select", weIdLog[base[5:0]], 0);

    // R9 ID path reaches the special region
    idPathEn = 1; base = weCnt;
    i2cStart(); sendByte({NVC, 1'b0}, ack); sendByte(8'h85, ack); sendByte(8'h77, ack);
    i2cStop();
    chk(weAddrLog[base[5:0]] == 8'h85, "R9 full addr", weAddrLog[base[5:0]], 8'h85);
    chk(weIdLog[base[5:0]] == 1, "R9 id select", weIdLog[base[5:0]], 1);
    i2cStart(); sendByte({NVC, 1'b0}, ack); sendByte(8'h85, ack);
    i2cStart(); sendByte({NVC, 1'b1}, ack); readByte(0, v0); i2cStop();
    chk(v0 == 8'h77, "R9 readback", v0, 8'h77);
    idPathEn = 0;

    // R10 clocking without a Start after Stop
    base = weCnt; oe0 = oeCnt;
    sclM = 0; qw();
    sendByte({NVC, 1'b0}, ack); sendByte(8'h12, ack);
    chk(ack == 0, "R10 no ack", ack, 0);
    chk(oeCnt == oe0 && weCnt == base, "R10 silent", oeCnt - oe0, 0);
    i2cStop();

    finishRun();
  end
endmodule